// File: doc/BRIEF.md
# CEC Receive Frame Buffer

This block sits behind a bit-level consumer-electronics-control receiver and keeps the frames that are addressed to this device until software collects them. The receiver delivers one complete frame per transfer: a header byte, an opcode byte, an operand count, up to fourteen operand bytes and an error flag. The block checks the destination nibble of the header against a 16-bit acceptance mask. It stores accepted frames whole in a small first-in first-out queue.

Software sees only the oldest queued frame, through a byte-wide register port. It reads a combined status byte, then the header, opcode and operands. It then removes the frame with a self-clearing pop command, or discards everything with a flush command. A sticky status bit is set for each accepted frame and another for each accepted frame that found the queue full. Each bit can drive the interrupt output through its own enable.

The frame input is a valid/ready stream. `in_ready` is low only while a pop or flush command is pending. The upstream receiver must hold the frame and `in_valid` stable until it sees `in_ready` high. Any frame presented while `in_ready` is high is consumed in that cycle: it is stored, filtered out, or dropped on overflow. The block never stalls for a full queue.

Top module: `cec_rx_frame_buffer`

## Requirements
- R1: After reset the following all read 0: status (0x00), control (0x04), interrupt status (0x10), interrupt enable (0x14), mask low (0x18) and mask high (0x1C). After reset `irq` is 0 and `in_ready` is 1.
- R2: A consumed frame is stored only if mask bit D is set, where D is `in_header[3:0]`. Register 0x18 holds mask bits 0–7 and register 0x1C holds mask bits 8–15. With both registers zero, no frame is stored.
- R3: The status register 0x00 reads as follows for the oldest frame: bits [3:0] give its operand count, bits [6:4] give the number of queued frames, and bit 7 gives its error flag. The register reads 0 when the queue is empty.
- R4: The header reads at 0x08 and the opcode at 0x0C. Operand i, taken from `in_operands[8*i+7:8*i]`, reads at 0x40+4*i for i = 0..13. Operand slots at or beyond the frame's operand count read 0. An input count above 14 is stored as 14.
- R5: A frame with `in_err` set is queued like any other frame. It shows its flag in status bit 7 and leaves the queue only by pop or flush.
- R6: Writing bit 0 of control (0x04) with bit 1 clear requests a pop. Control then reads 0x01 for exactly one cycle, then reads 0 and the oldest frame is gone. A pop on an empty queue changes nothing. Control writes made while a command is pending are ignored.
- R7: Writing control with bit 1 set requests a flush. Control then reads 0x03 for exactly one cycle, then reads 0 and the queue is empty.
- R8: Frames leave the queue in arrival order, and up to 4 frames are held. A frame that passes the mask while 4 are queued is dropped, and interrupt status bit 3 is set.
- R9: Interrupt status bit 1 is set for every stored frame. Writing 1 to a bit of interrupt status clears it, writing 0 leaves it, and a set in the same cycle wins.
- R10: `irq` is 1 exactly when some bit is 1 both in interrupt status (0x10) and in interrupt enable (0x14).
- R11: `in_ready` is 0 while a pop or flush is pending and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame on the input is valid |
| in_ready | output | 1 | Block consumes the frame this cycle |
| in_header | input | 8 | Header byte, destination in bits [3:0] |
| in_opcode | input | 8 | Opcode byte |
| in_nops | input | 4 | Number of operand bytes |
| in_operands | input | 112 | Operand bytes, operand i in bits [8i+7:8i] |
| in_err | input | 1 | Frame was received with an error |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a write to the control register is never made in the same cycle as a frame transfer that would need the pop to free a slot. They also assume that the upstream receiver keeps its frame steady while `in_ready` is low. The stimulus respects both: it changes inputs only on the falling clock edge, and it issues a frame only after it sees `in_ready` high. Every command is allowed to finish before the next register access. The operand-count sweep deliberately includes the illegal counts 15, so the clipping rule is exercised under the same protocol.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  localparam int MAX_OPS  = 14;
  localparam int NOPS_W   = 4;
  localparam int REG_AW   = 8;
  localparam int N_LADDR  = 16;

  localparam logic [REG_AW-1:0] A_STAT = 8'h00;
  localparam logic [REG_AW-1:0] A_CTRL = 8'h04;
  localparam logic [REG_AW-1:0] A_HDR  = 8'h08;
  localparam logic [REG_AW-1:0] A_OPC  = 8'h0C;
  localparam logic [REG_AW-1:0] A_ISR  = 8'h10;
  localparam logic [REG_AW-1:0] A_IER  = 8'h14;
  localparam logic [REG_AW-1:0] A_MLO  = 8'h18;
  localparam logic [REG_AW-1:0] A_MHI  = 8'h1C;
  localparam logic [REG_AW-1:0] A_OPS  = 8'h40;

  typedef struct packed {
    logic                 err;
    logic [NOPS_W-1:0]    nops;
    logic [7:0]           hdr;
    logic [7:0]           opc;
    logic [MAX_OPS*8-1:0] ops;
  } cec_frame_t;
endpackage

// File: rtl/cec_rx_addr_filter.sv
module cec_rx_addr_filter #(
  parameter int ADDRS = 16,
  localparam int DW = $clog2(ADDRS)
) (
  input  logic [ADDRS-1:0] mask,
  input  logic [DW-1:0]    dest,
  output logic             hit
);
  logic [ADDRS-1:0] sel;

  for (genvar g = 0; g < ADDRS; g++) begin : g_dec
    assign sel[g] = (dest == DW'(g));
  end

  assign hit = |(sel & mask);
endmodule

// File: rtl/cec_rx_frame_queue.sv
module cec_rx_frame_queue
  import cec_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  cec_frame_t       din,
  input  logic             pop,
  input  logic             flush,
  output cec_frame_t       head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  cec_frame_t mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R7
endmodule

// File: rtl/cec_rx_frame_buffer.sv
module cec_rx_frame_buffer
  import cec_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_header,
  input  logic [7:0]           in_opcode,
  input  logic [NOPS_W-1:0]    in_nops,
  input  logic [MAX_OPS*8-1:0] in_operands,
  input  logic                 in_err,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic                 irq
);
  logic [7:0] mask_lo, mask_hi, ier;
  logic       isr_ne, isr_ovf;
  logic [1:0] ctrl;
  logic       accept, hit, push, ovf;
  cec_frame_t fin, head;
  logic [CNT_W-1:0] q_count;
  logic       q_full, q_empty;
  logic [7:0] isr_v, stat_v, op_byte;
  logic [REG_AW-1:0] op_off;
  logic [3:0] op_idx;
  logic       op_hit;

  assign in_ready = (ctrl == 2'b00);
  assign accept   = in_valid && in_ready;
  assign push     = accept && hit && !q_full;
  assign ovf      = accept && hit && q_full;

  always_comb begin
    fin.err  = in_err;
    fin.nops = (in_nops > NOPS_W'(MAX_OPS)) ? NOPS_W'(MAX_OPS) : in_nops;
    fin.hdr  = in_header;
    fin.opc  = in_opcode;
    fin.ops  = in_operands;
  end

  cec_rx_addr_filter #(.ADDRS(N_LADDR)) u_filter (
    .mask ({mask_hi, mask_lo}),
    .dest (in_header[3:0]),
    .hit  (hit)
  );

  cec_rx_frame_queue #(.DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (fin),
    .pop   (ctrl == 2'b01),
    .flush (ctrl[1]),
    .head  (head),
    .count (q_count),
    .full  (q_full),
    .empty (q_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_lo <= '0;
      mask_hi <= '0;
      ier     <= '0;
      isr_ne  <= 1'b0;
      isr_ovf <= 1'b0;
      ctrl    <= 2'b00;
    end else begin
      if (ctrl != 2'b00)
        ctrl <= 2'b00;
      else if (reg_we && reg_addr == A_CTRL)
        ctrl <= reg_wdata[1] ? 2'b11 : {1'b0, reg_wdata[0]};
      if (reg_we && reg_addr == A_MLO) mask_lo <= reg_wdata;
      if (reg_we && reg_addr == A_MHI) mask_hi <= reg_wdata;
      if (reg_we && reg_addr == A_IER) ier <= reg_wdata;
      isr_ne  <= (isr_ne  && !(reg_we && reg_addr == A_ISR && reg_wdata[1])) || push;
      isr_ovf <= (isr_ovf && !(reg_we && reg_addr == A_ISR && reg_wdata[3])) || ovf;
    end
  end

  assign isr_v  = {4'b0, isr_ovf, 1'b0, isr_ne, 1'b0};
  assign irq    = |(isr_v & ier);
  assign stat_v = q_empty ? 8'h00 : {head.err, 3'(q_count), head.nops};

  assign op_off = reg_addr - A_OPS;
  assign op_idx = op_off[5:2];
  assign op_hit = (reg_addr >= A_OPS) && (op_off < REG_AW'(4 * MAX_OPS)) &&
                  (op_off[1:0] == 2'b00);

  always_comb begin
    op_byte = 8'h00;
    for (int i = 0; i < MAX_OPS; i++)
      if (op_idx == 4'(i)) op_byte = head.ops[i*8 +: 8];
    if (q_empty || op_idx >= head.nops) op_byte = 8'h00;
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (op_hit) reg_rdata = op_byte;
    else begin
      case (reg_addr)
        A_STAT: reg_rdata = stat_v;
        A_CTRL: reg_rdata = {6'b0, ctrl};
        A_HDR:  reg_rdata = q_empty ? 8'h00 : head.hdr;
        A_OPC:  reg_rdata = q_empty ? 8'h00 : head.opc;
        A_ISR:  reg_rdata = isr_v;
        A_IER:  reg_rdata = ier;
        A_MLO:  reg_rdata = mask_lo;
        A_MHI:  reg_rdata = mask_hi;
        default: reg_rdata = 8'h00;
      endcase
    end
  end

  AST_FILTER_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> $stable(q_count)); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && q_full) |=> (isr_ovf && q_count == CNT_W'(DEPTH))); // R8
  AST_POP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 2'b01 && !q_empty && !push) |=> (q_count == $past(q_count) - 1'b1)); // R6
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl != 2'b00) |=> (ctrl == 2'b00 && in_ready)); // R11
  AST_STORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> isr_ne); // R9
endmodule

// File: tb/cec_rx_frame_buffer_test.sv
module cec_rx_frame_buffer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_err = 1'b0, reg_we = 1'b0;
  logic in_ready, irq;
  logic [7:0] in_header = '0, in_opcode = '0, reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic [3:0] in_nops = '0;
  logic [111:0] in_operands = '0;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  cec_rx_frame_buffer uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] h, input logic [7:0] o, input int n,
                      input logic e);
    in_header = h; in_opcode = o; in_nops = 4'(n); in_err = e;
    for (int i = 0; i < 14; i++) in_operands[i*8 +: 8] = 8'(n * 16 + i + 1);
    in_valid = 1'b1; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_frame(input bit check_cmd);
    logic [7:0] d;
    wr(8'h04, 8'h01);
    if (check_cmd) begin
      rd(8'h04, d); chk("R6 pop pending", d, 1);
      chk("R11 ready low", in_ready, 0);
    end
    @(negedge clk);
    if (check_cmd) begin
      rd(8'h04, d); chk("R6 pop cleared", d, 0);
      chk("R11 ready back", in_ready, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (d[i]) ;
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4), d);
      if (a != 2 && a != 3) chk("R1 reset reg", d, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 ready", in_ready, 1);

    // R2 zero mask accepts nothing
    for (int t = 0; t < 16; t++) send(8'(8'h40 | t), 8'h11, 2, 1'b0);
    rd(8'h00, d); chk("R2 zero mask", d, 0);

    // R2 single-bit mask sweep over all destinations
    for (int dm = 0; dm < 16; dm++) begin
      wr(8'h18, (dm < 8) ? 8'(1 << dm) : 8'h00);
      wr(8'h1C, (dm >= 8) ? 8'(1 << (dm - 8)) : 8'h00);
      for (int t = 0; t < 16; t++) send(8'(((t + 3) % 16) * 16 + t), 8'(t), 1, 1'b0);
      rd(8'h00, d); chk("R2 one match", d, 8'h11);
      rd(8'h08, d); chk("R2 header", d, ((dm + 3) % 16) * 16 + dm);
      rd(8'h0C, d); chk("R4 opcode", d, dm);
      pop_frame(dm == 0);
    end
    rd(8'h00, d); chk("R6 emptied", d, 0);

    // R3 R4 operand count sweep including clip
    wr(8'h18, 8'hFF); wr(8'h1C, 8'hFF);
    for (int n = 0; n < 16; n++) begin
      int nc;
      nc = (n > 14) ? 14 : n;
      send(8'h4F, 8'(8'h80 + n), n, 1'b0);
      rd(8'h00, d); chk("R3 status", d, 8'h10 | nc);
      for (int i = 0; i < 14; i++) begin
        rd(8'(8'h40 + 4 * i), d);
        chk("R4 operand", d, (i < nc) ? ((n * 16 + i + 1) & 255) : 0);
      end
      pop_frame(1'b0);
    end

    // R6 pop on empty
    pop_frame(1'b1);
    rd(8'h00, d); chk("R6 empty pop", d, 0);

    // R8 R5 order, error flag, overflow
    wr(8'h10, 8'hFF);
    rd(8'h10, d); chk("R9 w1c all", d, 0);
    for (int k = 0; k < 5; k++) send(8'(8'h10 + k), 8'h22, 0, k[0]);
    rd(8'h00, d); chk("R8 full count", d[6:4], 4);
    rd(8'h10, d); chk("R8 overflow flag", d, 8'h0A);
    for (int k = 0; k < 4; k++) begin
      rd(8'h08, d); chk("R8 order", d, 8'h10 + k);
      rd(8'h00, d); chk("R5 err bit", d[7], k & 1);
      chk("R3 count", d[6:4], 4 - k);
      pop_frame(1'b0);
    end
    rd(8'h00, d); chk("R8 drained", d, 0);

    // R9 R10 interrupt behaviour
    wr(8'h10, 8'hFF);
    send(8'h03, 8'h44, 0, 1'b0);
    rd(8'h10, d); chk("R9 set on store", d, 8'h02);
    chk("R10 masked", irq, 0);
    wr(8'h14, 8'h02);
    chk("R10 enabled", irq, 1);
    wr(8'h10, 8'h00);
    rd(8'h10, d); chk("R9 write zero", d, 8'h02);
    wr(8'h10, 8'h02);
    rd(8'h10, d); chk("R9 w1c", d, 0);
    chk("R10 cleared", irq, 0);

    // R7 flush
    send(8'h05, 8'h01, 0, 1'b1);
    send(8'h06, 8'h02, 0, 1'b0);
    rd(8'h00, d); chk("R7 before", d[6:4], 3);
    wr(8'h04, 8'h03);
    rd(8'h04, d); chk("R7 pending", d, 3);
    chk("R11 ready low flush", in_ready, 0);
    @(negedge clk);
    rd(8'h04, d); chk("R7 cleared", d, 0);
    rd(8'h00, d); chk("R7 empty", d, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule